// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the single-root I/O virtualization extended capability of a physical function (PF). Configuration software reaches it through dword-wide reads and writes with per-byte enables. The address is a dword index relative to the capability base. Every writable field has a per-bit write mask. Some of these masks change at run time: turning VFs on freezes the VF count, and a VF count above the implemented total stops VFs from being turned on. The block drives the VF-enable flag, the number of active VFs, and the routing ID of each VF to the rest of the function.

The VF-enable behaviour is a two-state machine.

States:
- `ST_DISABLED`: VFs are off.
- `ST_ENABLED`: VFs are on.

Transitions:
- ENABLE (`ST_DISABLED` to `ST_ENABLED`): a control write with the enable bit set while enabling is allowed.
- DISABLE (`ST_ENABLED` to `ST_DISABLED`): a control write with the enable bit clear.
- FUNC_RESET (either state to `ST_DISABLED`): the function-reset input.

A one-cycle pulse marks every change of state. The VF BARs have per-BAR aperture sizes and type bits, fixed at elaboration. A BAR typed as 64-bit memory takes the next dword as its upper half.

Top module: `sriov_cap_regs`

## Requirements
- R1: The dword layout is as follows.
  - Index 0: header `{NEXT_PTR[11:0], 4'h1, 16'h0010}`.
  - Index 2: control in bits [15:0].
  - Index 3: `{TotalVFs, InitialVFs}`.
  - Index 4: NumVFs in bits [15:0], upper half zero.
  - Index 5: `{stride, first offset}`.
  - Index 6: `{VF device ID, 16'h0}`.
  - Index 7: supported page sizes.
  - Index 8: system page size.
  - Indices 9 to 14: VF BAR0 to BAR5.
  - Indices 1 and 15: zero.

  A read returns its data on `cfg_rdata` in the cycle after `cfg_rd_en`.
- R2: A read at an index of 16 or above returns zero. A write at such an index changes no register.
- R3: Writes merge byte by byte as `old & ~mask | new & mask`, for enabled bytes only. In control, only bit 0 (VF enable), bit 3 (VF memory space enable) and bit 4 (ARI hierarchy) are writable. All other control bits read zero.
- R4: While VFs are enabled, NumVFs ignores writes. After VFs are disabled, NumVFs is fully writable again.
- R5: A write to NumVFs (either low byte enabled) allows a later VF enable only if the new NumVFs is at most TotalVFs. Otherwise the enable bit is not writable, but bits 3 and 4 still are.
- R6: `num_active_vfs` equals NumVFs while `vf_enable` is 1, and is zero otherwise.
- R7: System page size resets to 0x0001. Its write mask equals the supported set, 0x553 OR'd with `EXTRA_PGSZ`. The supported set itself is read-only.
- R8: TotalVFs, InitialVFs, first offset, stride, VF device ID and the header are read-only parameters.
- R9: Each implemented VF BAR (size log2 not 0) resets to its type byte and has write mask `~(2**log2 - 1)`. An unimplemented BAR reads zero and ignores writes.
- R10: A BAR whose type has bit 0 = 0 and bits [2:1] = 2'b10 is 64-bit. The following dword is its upper half: it resets to 0 and its mask is bits [63:32] of the 64-bit mask.
- R11: `func_rst` disables VFs. It clears control and NumVFs, re-allows the VF enable bit, sets the system page size to 0x0001, and reloads each BAR with its reset value.
- R12: The routing ID of VF i is `{pf_bus, PF_DEVFN + FIRST_OFF + i*STRIDE}`. `vf_rid_valid[i]` is 1 only when i < `num_active_vfs`. Elaboration fails if the last VF's function number would reach 256.
- R13: `vf_en_pulse` is 1 for exactly the one cycle after each change of `vf_enable`, including a change caused by function reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| func_rst | input | 1 | Synchronous function reset |
| pf_bus | input | 8 | PF bus number |
| cfg_wr_en | input | 1 | Write strobe |
| cfg_rd_en | input | 1 | Read strobe |
| cfg_addr | input | ADDR_W | Dword index from capability base |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, one cycle after the read |
| vf_enable | output | 1 | VFs enabled |
| vf_en_pulse | output | 1 | One-cycle pulse on enable change |
| num_active_vfs | output | 16 | Active VF count |
| vf_rid | output | TOTAL_VFS*16 | Routing IDs, VF i at bits [i*16 +: 16] |
| vf_rid_valid | output | TOTAL_VFS | Per-VF active flag |

## Verification
The bench goes after the following corner cases:
- **Masked enable.** It sets NumVFs above TotalVFs and then writes the enable bit. A design that ignored the dynamic mask would bring up VFs with an out-of-range count.
- **Frozen NumVFs.** It writes NumVFs while VFs are on. A design that failed to lock it would change the active count under running VFs.
- **Function reset after a blocked count.** It confirms the enable bit is writable again after the reset. A design that kept the old mask would refuse enables forever.
- **BAR boundaries.** It writes all ones to the 64-bit pair, the I/O BAR and the unimplemented BARs. A wrong mask shows up as corrupted type bits or a writable size field.
- **Aliasing indices.** It writes indices above the capability's size that alias real registers when bits are dropped. An incomplete decode shows up there.

// File: rtl/sriov_pkg.sv
package sriov_pkg;

    typedef enum logic [0:0] {
        ST_DISABLED = 1'b0,
        ST_ENABLED  = 1'b1
    } vf_state_t;

    localparam int CAP_DWORDS = 16;
    localparam int IDX_HDR    = 0;
    localparam int IDX_CTRL   = 2;
    localparam int IDX_COUNTS = 3;
    localparam int IDX_NUMVF  = 4;
    localparam int IDX_ROUTE  = 5;
    localparam int IDX_DEVID  = 6;
    localparam int IDX_SUPPG  = 7;
    localparam int IDX_SYSPG  = 8;
    localparam int IDX_BAR0   = 9;
    localparam int NUM_BARS   = 6;

    localparam int CTL_VFE = 0;
    localparam int CTL_MSE = 3;
    localparam int CTL_ARI = 4;

    localparam logic [15:0] MIN_PGSZ = 16'h0553;

    function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be,
                                               input logic [31:0] mask);
        logic [31:0] r;
        r = old_v;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) begin
                r[b*8 +: 8] = (old_v[b*8 +: 8] & ~mask[b*8 +: 8]) |
                              (new_v[b*8 +: 8] & mask[b*8 +: 8]);
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] aperture_mask(input int log2_size);
        logic [63:0] m;
        if (log2_size == 0) begin
            m = '0;
        end else begin
            m = ~((64'd1 << log2_size) - 64'd1);
        end
        return m;
    endfunction

endpackage

// File: rtl/sriov_ctrl_fsm.sv
module sriov_ctrl_fsm
    import sriov_pkg::*;
#(
    parameter int TOTAL_VFS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        func_rst,
    input  logic        ctrl_wr,
    input  logic        numvf_wr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic        vf_enable,
    output logic        vf_en_pulse,
    output logic        mse_q,
    output logic        ari_q,
    output logic [15:0] numvf_q
);

    vf_state_t   st, st_nx;
    logic        vfe_ok_q;
    logic [15:0] numvf_nx;
    logic [15:0] numvf_mask;

    assign vf_enable  = (st == ST_ENABLED);
    assign numvf_mask = vf_enable ? 16'h0000 : 16'hFFFF;
    assign numvf_nx   = 16'(byte_merge({16'h0, numvf_q}, wdata,
                                       {2'b00, be[1:0]}, {16'h0, numvf_mask}));

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_DISABLED: if (ctrl_wr && vfe_ok_q && wdata[CTL_VFE])  st_nx = ST_ENABLED;
            ST_ENABLED:  if (ctrl_wr && vfe_ok_q && !wdata[CTL_VFE]) st_nx = ST_DISABLED;
            default:     st_nx = ST_DISABLED;
        endcase
        if (func_rst) st_nx = ST_DISABLED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_DISABLED;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vf_en_pulse <= 1'b0;
            mse_q       <= 1'b0;
            ari_q       <= 1'b0;
            numvf_q     <= '0;
            vfe_ok_q    <= 1'b1;
        end else begin
            vf_en_pulse <= (st_nx != st);
            if (func_rst) begin
                mse_q    <= 1'b0;
                ari_q    <= 1'b0;
                numvf_q  <= '0;
                vfe_ok_q <= 1'b1;
            end else if (ctrl_wr) begin
                mse_q <= wdata[CTL_MSE];
                ari_q <= wdata[CTL_ARI];
            end else if (numvf_wr) begin
                numvf_q  <= numvf_nx;
                vfe_ok_q <= (numvf_nx <= 16'(TOTAL_VFS));
            end
        end
    end

    assert_numvf_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vf_enable && !func_rst) |=> $stable(numvf_q));

    assert_enable_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vf_enable) |-> (numvf_q <= 16'(TOTAL_VFS)));

    assert_pulse_on_change_R13: assert property (@(posedge clk) disable iff (!rst_n)
        vf_en_pulse |-> (vf_enable != $past(vf_enable)));

    assert_func_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        func_rst |=> (!vf_enable && numvf_q == 16'h0));

endmodule

// File: rtl/sriov_vf_bar.sv
module sriov_vf_bar
    import sriov_pkg::*;
#(
    parameter int                         IDX       = 0,
    parameter logic [NUM_BARS*8-1:0]      BAR_TYPE  = '0,
    parameter logic [NUM_BARS*8-1:0]      BAR_LOG2  = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        func_rst,
    input  logic        wr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] val
);

    localparam logic [7:0] OWN_TYPE = BAR_TYPE[IDX*8 +: 8];
    localparam int         OWN_LOG2 = int'(BAR_LOG2[IDX*8 +: 8]);
    localparam logic [7:0] PRV_TYPE = (IDX > 0) ? BAR_TYPE[((IDX > 0) ? IDX-1 : 0)*8 +: 8] : 8'h00;
    localparam int         PRV_LOG2 = (IDX > 0) ? int'(BAR_LOG2[((IDX > 0) ? IDX-1 : 0)*8 +: 8]) : 0;
    localparam bit         IS_UPPER = (IDX > 0) && !PRV_TYPE[0] &&
                                      (PRV_TYPE[2:1] == 2'b10) && (PRV_LOG2 != 0);
    localparam logic [63:0] PRV_M64 = aperture_mask(PRV_LOG2);
    localparam logic [63:0] OWN_M64 = aperture_mask(OWN_LOG2);
    localparam logic [31:0] MASK    = IS_UPPER ? PRV_M64[63:32] : OWN_M64[31:0];
    localparam logic [31:0] RST_VAL = (IS_UPPER || OWN_LOG2 == 0) ? 32'h0 : {24'h0, OWN_TYPE};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        val <= RST_VAL;
        else if (func_rst) val <= RST_VAL;
        else if (wr)       val <= byte_merge(val, wdata, be, MASK);
    end

    assert_ro_bits_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !func_rst) |=> ((val & ~MASK) == ($past(val) & ~MASK)));

endmodule

// File: rtl/sriov_rid_gen.sv
module sriov_rid_gen #(
    parameter int TOTAL_VFS = 8,
    parameter int PF_DEVFN  = 0,
    parameter int FIRST_OFF = 1,
    parameter int STRIDE    = 1
) (
    input  logic [7:0]              pf_bus,
    input  logic [15:0]             num_active,
    output logic [TOTAL_VFS*16-1:0] vf_rid,
    output logic [TOTAL_VFS-1:0]    vf_rid_valid
);

    localparam int LAST_FN = PF_DEVFN + FIRST_OFF + (TOTAL_VFS - 1) * STRIDE;

    // R12: reject a layout whose last VF function number leaves the bus
    if (LAST_FN >= 256) begin : g_bad_layout
        $error("sriov_rid_gen: last VF function number exceeds 255");
    end

    for (genvar i = 0; i < TOTAL_VFS; i++) begin : g_vf
        localparam int FN = PF_DEVFN + FIRST_OFF + i * STRIDE;
        assign vf_rid[i*16 +: 16] = {pf_bus, 8'(FN)};
        assign vf_rid_valid[i]    = (16'(i) < num_active);
    end

endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
    import sriov_pkg::*;
#(
    parameter int                    ADDR_W      = 6,
    parameter int                    TOTAL_VFS   = 8,
    parameter int                    INITIAL_VFS = 8,
    parameter int                    FIRST_OFF   = 1,
    parameter int                    STRIDE      = 2,
    parameter int                    PF_DEVFN    = 0,
    parameter logic [15:0]           VF_DEVID    = 16'hABCD,
    parameter logic [11:0]           NEXT_PTR    = 12'h000,
    parameter logic [15:0]           EXTRA_PGSZ  = 16'h0000,
    parameter logic [NUM_BARS*8-1:0] BAR_TYPE    = {8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h0C},
    parameter logic [NUM_BARS*8-1:0] BAR_LOG2    = {8'd0, 8'd0, 8'd8, 8'd12, 8'd0, 8'd20}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    func_rst,
    input  logic [7:0]              pf_bus,
    input  logic                    cfg_wr_en,
    input  logic                    cfg_rd_en,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [3:0]              cfg_be,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    output logic                    vf_enable,
    output logic                    vf_en_pulse,
    output logic [15:0]             num_active_vfs,
    output logic [TOTAL_VFS*16-1:0] vf_rid,
    output logic [TOTAL_VFS-1:0]    vf_rid_valid
);

    localparam logic [15:0] SUP_PGSZ = MIN_PGSZ | EXTRA_PGSZ;

    logic        in_cap;
    logic [3:0]  idx;
    logic        mse_q, ari_q;
    logic [15:0] numvf_q;
    logic [15:0] syspg_q;
    logic [31:0] bar_val [NUM_BARS];
    logic [31:0] rd_mux;

    assign in_cap = (cfg_addr < ADDR_W'(CAP_DWORDS));
    assign idx    = cfg_addr[3:0];

    sriov_ctrl_fsm #(.TOTAL_VFS(TOTAL_VFS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .func_rst    (func_rst),
        .ctrl_wr     (cfg_wr_en && in_cap && idx == 4'(IDX_CTRL) && cfg_be[0]),
        .numvf_wr    (cfg_wr_en && in_cap && idx == 4'(IDX_NUMVF) && (cfg_be[1:0] != 2'b00)),
        .be          (cfg_be),
        .wdata       (cfg_wdata),
        .vf_enable   (vf_enable),
        .vf_en_pulse (vf_en_pulse),
        .mse_q       (mse_q),
        .ari_q       (ari_q),
        .numvf_q     (numvf_q)
    );

    assign num_active_vfs = vf_enable ? numvf_q : 16'h0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        syspg_q <= 16'h0001;
        else if (func_rst) syspg_q <= 16'h0001;
        else if (cfg_wr_en && in_cap && idx == 4'(IDX_SYSPG))
            syspg_q <= 16'(byte_merge({16'h0, syspg_q}, cfg_wdata, cfg_be, {16'h0, SUP_PGSZ}));
    end

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        sriov_vf_bar #(.IDX(g), .BAR_TYPE(BAR_TYPE), .BAR_LOG2(BAR_LOG2)) u_bar (
            .clk      (clk),
            .rst_n    (rst_n),
            .func_rst (func_rst),
            .wr       (cfg_wr_en && in_cap && idx == 4'(IDX_BAR0 + g)),
            .be       (cfg_be),
            .wdata    (cfg_wdata),
            .val      (bar_val[g])
        );
    end

    sriov_rid_gen #(
        .TOTAL_VFS (TOTAL_VFS),
        .PF_DEVFN  (PF_DEVFN),
        .FIRST_OFF (FIRST_OFF),
        .STRIDE    (STRIDE)
    ) u_rid (
        .pf_bus       (pf_bus),
        .num_active   (num_active_vfs),
        .vf_rid       (vf_rid),
        .vf_rid_valid (vf_rid_valid)
    );

    always_comb begin
        rd_mux = 32'h0;
        if (in_cap) begin
            case (idx)
                4'(IDX_HDR):    rd_mux = {NEXT_PTR, 4'h1, 16'h0010};
                4'(IDX_CTRL):   rd_mux = {27'h0, ari_q, mse_q, 2'b00, vf_enable};
                4'(IDX_COUNTS): rd_mux = {16'(TOTAL_VFS), 16'(INITIAL_VFS)};
                4'(IDX_NUMVF):  rd_mux = {16'h0, numvf_q};
                4'(IDX_ROUTE):  rd_mux = {16'(STRIDE), 16'(FIRST_OFF)};
                4'(IDX_DEVID):  rd_mux = {VF_DEVID, 16'h0};
                4'(IDX_SUPPG):  rd_mux = {16'h0, SUP_PGSZ};
                4'(IDX_SYSPG):  rd_mux = {16'h0, syspg_q};
                default: begin
                    for (int b = 0; b < NUM_BARS; b++) begin
                        if (idx == 4'(IDX_BAR0 + b)) rd_mux = bar_val[b];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_rdata <= '0;
        else if (cfg_rd_en) cfg_rdata <= rd_mux;
    end

    assert_oor_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_rd_en && !in_cap) |-> (cfg_rdata == 32'h0));

    assert_ctrl_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_rd_en && in_cap && idx == 4'(IDX_CTRL)) |->
        (cfg_rdata[31:5] == 27'h0 && cfg_rdata[2:1] == 2'b00));

endmodule

// File: tb/sriov_cap_regs_tb.sv
module sriov_cap_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          func_rst = 1'b0;
    logic [7:0]    pf_bus = 8'h3A;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_rd_en = 1'b0;
    logic [5:0]    cfg_addr = '0;
    logic [3:0]    cfg_be = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          vf_enable, vf_en_pulse;
    logic [15:0]   num_active_vfs;
    logic [NV*16-1:0] vf_rid;
    logic [NV-1:0] vf_rid_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sriov_cap_regs u_dut (
        .clk(clk), .rst_n(rst_n), .func_rst(func_rst), .pf_bus(pf_bus),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .vf_enable(vf_enable), .vf_en_pulse(vf_en_pulse),
        .num_active_vfs(num_active_vfs), .vf_rid(vf_rid), .vf_rid_valid(vf_rid_valid)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 6'(a); cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_addr = 6'(a);
        @(negedge clk);
        cfg_rd_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse_frst();
        @(negedge clk);
        func_rst = 1'b1;
        @(negedge clk);
        func_rst = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R6 reset enable", {31'h0, vf_enable}, 32'h0);
        chk("R6 reset active", {16'h0, num_active_vfs}, 32'h0);
        rd_chk("R1 header", 0, 32'h0001_0010);
        rd_chk("R1 index1", 1, 32'h0);
        rd_chk("R3 ctrl reset", 2, 32'h0);
        rd_chk("R1 counts", 3, 32'h0008_0008);
        rd_chk("R1 numvf reset", 4, 32'h0);
        rd_chk("R1 route", 5, 32'h0002_0001);
        rd_chk("R1 devid", 6, 32'hABCD_0000);
        rd_chk("R7 supported", 7, 32'h0000_0553);
        rd_chk("R7 sys reset", 8, 32'h0000_0001);
        rd_chk("R9 bar0 type", 9, 32'h0000_000C);
        rd_chk("R10 bar1 upper", 10, 32'h0);
        rd_chk("R9 bar2 type", 11, 32'h0);
        rd_chk("R9 bar3 io type", 12, 32'h0000_0001);
        rd_chk("R1 index15", 15, 32'h0);
    endtask

    task automatic t_ctrl_mask();
        wr(2, 4'hF, 32'hFFFF_FFFE);
        rd_chk("R3 ctrl writable bits", 2, 32'h0000_0018);
        chk("R3 enable untouched", {31'h0, vf_enable}, 32'h0);
        wr(2, 4'hF, 32'h0);
        rd_chk("R3 ctrl cleared", 2, 32'h0);
    endtask

    task automatic t_enable_flow();
        wr(4, 4'h3, 32'hFFFF_0005);
        rd_chk("R1 numvf write", 4, 32'h0000_0005);
        wr(2, 4'h1, 32'h1);
        chk("R13 rise pulse", {31'h0, vf_en_pulse}, 32'h1);
        chk("R6 enabled", {31'h0, vf_enable}, 32'h1);
        chk("R6 active five", {16'h0, num_active_vfs}, 32'h5);
        chk("R12 valid mask", {24'h0, vf_rid_valid}, 32'h1F);
        chk("R12 rid0", {16'h0, vf_rid[0 +: 16]}, 32'h3A01);
        chk("R12 rid4", {16'h0, vf_rid[64 +: 16]}, 32'h3A09);
        chk("R12 rid7 last", {16'h0, vf_rid[112 +: 16]}, 32'h3A0F);
        @(negedge clk);
        chk("R13 pulse one cycle", {31'h0, vf_en_pulse}, 32'h0);
        wr(4, 4'h3, 32'h7);
        rd_chk("R4 numvf locked", 4, 32'h5);
        chk("R4 active unchanged", {16'h0, num_active_vfs}, 32'h5);
        wr(2, 4'h1, 32'h0);
        chk("R13 fall pulse", {31'h0, vf_en_pulse}, 32'h1);
        chk("R6 active zero", {16'h0, num_active_vfs}, 32'h0);
        chk("R12 valid clear", {24'h0, vf_rid_valid}, 32'h0);
        wr(4, 4'h3, 32'h7);
        rd_chk("R4 numvf unlocked", 4, 32'h7);
    endtask

    task automatic t_blocked_enable();
        wr(4, 4'h3, 32'h9);
        wr(2, 4'h1, 32'h1);
        chk("R5 enable blocked", {31'h0, vf_enable}, 32'h0);
        wr(2, 4'h1, 32'h19);
        rd_chk("R5 mse ari still writable", 2, 32'h18);
        wr(4, 4'h3, 32'h8);
        wr(2, 4'h1, 32'h1);
        chk("R5 enable at total", {31'h0, vf_enable}, 32'h1);
        chk("R6 active eight", {16'h0, num_active_vfs}, 32'h8);
        chk("R12 all valid", {24'h0, vf_rid_valid}, 32'hFF);
        wr(2, 4'h1, 32'h0);
    endtask

    task automatic t_byte_merge();
        wr(4, 4'h2, 32'h0000_0300);
        rd_chk("R3 high byte only", 4, 32'h0000_0308);
        wr(4, 4'h1, 32'hFFFF_FF44);
        rd_chk("R3 low byte only", 4, 32'h0000_0344);
        wr(2, 4'h1, 32'h1);
        chk("R5 blocked after byte write", {31'h0, vf_enable}, 32'h0);
    endtask

    task automatic t_page_size();
        wr(8, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R7 sys mask", 8, 32'h0000_0553);
        wr(7, 4'hF, 32'h0);
        rd_chk("R7 supported ro", 7, 32'h0000_0553);
    endtask

    task automatic t_read_only();
        wr(0, 4'hF, 32'h0);
        wr(3, 4'hF, 32'h0);
        wr(5, 4'hF, 32'hFFFF_FFFF);
        wr(6, 4'hF, 32'h0);
        rd_chk("R8 header ro", 0, 32'h0001_0010);
        rd_chk("R8 counts ro", 3, 32'h0008_0008);
        rd_chk("R8 route ro", 5, 32'h0002_0001);
        rd_chk("R8 devid ro", 6, 32'hABCD_0000);
    endtask

    task automatic t_bars();
        for (int k = 9; k <= 14; k++) wr(k, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R10 bar0 low mask", 9, 32'hFFF0_000C);
        rd_chk("R10 bar1 high mask", 10, 32'hFFFF_FFFF);
        rd_chk("R9 bar2 4k mask", 11, 32'hFFFF_F000);
        rd_chk("R9 bar3 io mask", 12, 32'hFFFF_FF01);
        rd_chk("R9 bar4 unimpl", 13, 32'h0);
        rd_chk("R9 bar5 unimpl", 14, 32'h0);
        wr(11, 4'h2, 32'h1234_5678);
        rd_chk("R9 bar2 byte merge", 11, 32'hFFFF_5000);
    endtask

    task automatic t_out_of_range();
        wr(40, 4'hF, 32'h1);
        wr(34, 4'hF, 32'h19);
        rd_chk("R2 oor read", 40, 32'h0);
        rd_chk("R2 oor read 63", 63, 32'h0);
        rd_chk("R2 alias sys kept", 8, 32'h0000_0553);
        rd_chk("R2 alias ctrl kept", 2, 32'h0);
    endtask

    task automatic t_func_reset();
        pulse_frst();
        wr(2, 4'h1, 32'h1);
        chk("R11 enable allowed again", {31'h0, vf_enable}, 32'h1);
        chk("R11 active zero count", {16'h0, num_active_vfs}, 32'h0);
        wr(2, 4'h1, 32'h0);
        wr(4, 4'h3, 32'h3);
        wr(2, 4'h1, 32'h19);
        chk("R6 active three", {16'h0, num_active_vfs}, 32'h3);
        wr(8, 4'h1, 32'h10);
        @(negedge clk);
        pulse_frst();
        chk("R13 reset pulse", {31'h0, vf_en_pulse}, 32'h1);
        chk("R11 disabled", {31'h0, vf_enable}, 32'h0);
        rd_chk("R11 ctrl clear", 2, 32'h0);
        rd_chk("R11 numvf clear", 4, 32'h0);
        rd_chk("R11 sys page", 8, 32'h1);
        rd_chk("R11 bar0 reload", 9, 32'h0000_000C);
        rd_chk("R11 bar1 reload", 10, 32'h0);
        rd_chk("R11 bar3 reload", 12, 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_ctrl_mask();
        t_enable_flow();
        t_blocked_enable();
        t_byte_merge();
        t_page_size();
        t_read_only();
        t_bars();
        t_out_of_range();
        t_func_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule